// File: doc/BRIEF.md
# Processor Clock Throttling Controller

This block lowers processor power by pulling an active-low stop-clock request for a programmable share of every throttle period. A period is split into eight equal slots. A 3-bit duty code sets how many of the leading slots carry the request. A period-select field sets the slot length as a multiple of an external timebase tick.

Two sources can ask for throttling. Normal throttling is switched on by a software enable bit and uses its own duty code. Thermal throttling is switched on by an active-low thermal pin, which passes through a two-flop synchronizer and is gated by a thermal enable bit. It also has its own duty code, and that code wins whenever both sources are active.

The block acts only while the power-state input reports the fully-on state. When the system leaves that state, the request is dropped at once. When the system returns, a fresh period starts automatically. Settings are picked up only at a period start, so a change never produces a shortened pulse.

Top module: `cpu_throttle`

## Requirements
- R1: While reset is held, and after it is released until throttling starts, `stpclk_n` is 1.
- R2: One slot lasts `BASE_SLOT_TICKS << period_sel` ticks, where a tick is a cycle with `tick` = 1. A period is 8 slots. With `tick` held at 0, the slot does not advance.
- R3: Slots are numbered 0 to 7 from the start of the period. `stpclk_n` is 0 in slots 0 to duty-1 and 1 in the other slots, so duty 0 never asserts and slot 7 is always high.
- R4: With `norm_en` = 1 and the thermal source inactive, the duty code is `norm_duty`.
- R5: The thermal source is active when `therm_en` = 1 and `therm_n` = 0. The pin is synchronized through two flops, and the source then uses `therm_duty`.
- R6: When both sources are active, `therm_duty` is used.
- R7: When neither source is active at a period start, `stpclk_n` stays 1 for that whole period.
- R8: Changes to the enables, the duty codes, `period_sel` or the thermal pin take effect only at the next period start.
- R9: Power-state encoding: 2'b00 is fully on, and every other value is not. From the first edge at which `pwr_state` is not 2'b00, `stpclk_n` is 1 and the slot position is cleared.
- R10: On the edge where `pwr_state` returns to 2'b00, a new period starts at slot 0 with the current settings, and no software action is needed. The output for slot 0 appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase tick, one cycle per tick |
| pwr_state | input | 2 | System power state; 2'b00 is fully on |
| period_sel | input | 2 | Slot length select (shift of the base slot length) |
| norm_en | input | 1 | Normal throttle enable |
| norm_duty | input | 3 | Normal throttle duty, in slots out of 8 |
| therm_en | input | 1 | Thermal throttle enable |
| therm_n | input | 1 | Asynchronous active-low thermal pin |
| therm_duty | input | 3 | Thermal throttle duty, in slots out of 8 |
| stpclk_n | output | 1 | Active-low stop-clock request |

## Verification
The assertions check the following on every cycle:
- the output is high after reset and after any edge outside the fully-on state;
- slot 7 is never asserted;
- the slot position moves only on a tick or a power-state exit;
- the latched duty changes only on a period start;
- a low output always comes with a latched active source.

The bench scenarios show what a property cannot easily express:
- the exact low/high pattern across whole periods for several duty codes and slot lengths;
- thermal priority, taken after the synchronizer delay;
- a mid-period change that shows up only in the following period;
- a clean restart at slot 0 after the system leaves and re-enters the fully-on state.

// File: rtl/thr_pkg.sv
// Shared constants for the processor clock throttling controller.
// Assumes a 2-bit power-state code in which a single value means fully on.
package thr_pkg;
    localparam int PWR_W = 2;
    localparam logic [PWR_W-1:0] PWR_FULL_ON = 2'b00;
endpackage

// File: rtl/thr_sync.sv
// Two-flop synchronizer for one asynchronous level input.
// Assumes the input is a slow level, so metastability settles within one flop.
module thr_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Shift the raw level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/thr_mode_sel.sv
// Combinational source arbitration: decides whether throttling is requested
// and which duty code applies, with the thermal source taking priority.
// Assumes therm_act is already synchronized and active high.
module thr_mode_sel #(
    parameter int DUTY_W = 3
) (
    input  logic              norm_en,
    input  logic [DUTY_W-1:0] norm_duty,
    input  logic              therm_en,
    input  logic              therm_act,
    input  logic [DUTY_W-1:0] therm_duty,
    output logic              req_active,
    output logic [DUTY_W-1:0] req_duty
);
    logic therm_req;

    // Pick the requesting source and its duty, thermal first.
    always_comb begin
        therm_req  = therm_en && therm_act;
        req_active = therm_req || norm_en;
        if (therm_req) begin
            req_duty = therm_duty;
        end else if (norm_en) begin
            req_duty = norm_duty;
        end else begin
            req_duty = '0;
        end
    end
endmodule

// File: rtl/thr_timebase.sv
// Slot and period counter. Counts ticks within a slot and slots within a
// period; the slot length is latched at each period start.
// Assumes 'start' is a one-cycle pulse on entry to the running state and
// that the counters must be cleared whenever 'run' is low.
module thr_timebase #(
    parameter int DUTY_W          = 3,
    parameter int PSEL_W          = 2,
    parameter int BASE_SLOT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              tick,
    input  logic [PSEL_W-1:0] period_sel,
    output logic [DUTY_W-1:0] slot_idx,
    output logic              period_done
);
    localparam int MAX_SHIFT = (1 << PSEL_W) - 1;
    localparam int MAX_LEN   = BASE_SLOT_TICKS << MAX_SHIFT;
    localparam int LEN_W     = $clog2(MAX_LEN) + 1;
    localparam logic [DUTY_W-1:0] LAST_SLOT = {DUTY_W{1'b1}};

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_new;
    logic             slot_end;

    // Slot length requested by the current period select.
    always_comb begin
        len_new     = LEN_W'(BASE_SLOT_TICKS) << period_sel;
        slot_end    = run && !start && tick && (cnt_q == len_q - 1'b1);
        period_done = slot_end && (slot_idx == LAST_SLOT);
    end

    // Advance tick and slot counters; latch the slot length at period starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            slot_idx <= '0;
            len_q    <= LEN_W'(BASE_SLOT_TICKS);
        end else if (!run) begin
            cnt_q    <= '0;
            slot_idx <= '0;
        end else if (start) begin
            cnt_q    <= '0;
            slot_idx <= '0;
            len_q    <= len_new;
        end else if (tick) begin
            if (slot_end) begin
                cnt_q    <= '0;
                slot_idx <= slot_idx + 1'b1;
                if (period_done) begin
                    len_q <= len_new;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_throttle.sv
// Processor clock throttling controller top level. Drives an active-low
// stop-clock request for a duty share of each period while the system is
// fully on. Settings are sampled only at period starts.
// Assumes therm_n is asynchronous and all other inputs are in the clk domain.
module cpu_throttle #(
    parameter int DUTY_W          = 3,
    parameter int PSEL_W          = 2,
    parameter int BASE_SLOT_TICKS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [thr_pkg::PWR_W-1:0] pwr_state,
    input  logic [PSEL_W-1:0]         period_sel,
    input  logic                      norm_en,
    input  logic [DUTY_W-1:0]         norm_duty,
    input  logic                      therm_en,
    input  logic                      therm_n,
    input  logic [DUTY_W-1:0]         therm_duty,
    output logic                      stpclk_n
);
    import thr_pkg::*;

    logic              therm_n_s;
    logic              therm_act;
    logic              req_active;
    logic [DUTY_W-1:0] req_duty;
    logic              fon;
    logic              fon_q;
    logic              start;
    logic              period_done;
    logic              load;
    logic [DUTY_W-1:0] slot_idx;
    logic              act_q;
    logic [DUTY_W-1:0] duty_q;

    thr_sync #(.RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (therm_n),
        .q     (therm_n_s)
    );

    assign therm_act = !therm_n_s;

    thr_mode_sel #(.DUTY_W(DUTY_W)) u_mode (
        .norm_en    (norm_en),
        .norm_duty  (norm_duty),
        .therm_en   (therm_en),
        .therm_act  (therm_act),
        .therm_duty (therm_duty),
        .req_active (req_active),
        .req_duty   (req_duty)
    );

    // Decode the power state and mark period starts.
    always_comb begin
        fon   = (pwr_state == PWR_FULL_ON);
        start = fon && !fon_q;
        load  = start || period_done;
    end

    thr_timebase #(
        .DUTY_W          (DUTY_W),
        .PSEL_W          (PSEL_W),
        .BASE_SLOT_TICKS (BASE_SLOT_TICKS)
    ) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (fon),
        .start       (start),
        .tick        (tick),
        .period_sel  (period_sel),
        .slot_idx    (slot_idx),
        .period_done (period_done)
    );

    // Track the power state and latch the mode and duty at period starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fon_q  <= 1'b0;
            act_q  <= 1'b0;
            duty_q <= '0;
        end else begin
            fon_q <= fon;
            if (!fon) begin
                act_q <= 1'b0;
            end else if (load) begin
                act_q  <= req_active;
                duty_q <= req_duty;
            end
        end
    end

    // Request stop-clock in the leading duty slots of a running period.
    always_comb begin
        stpclk_n = !(fon_q && act_q && (slot_idx < duty_q));
    end
endmodule

// File: rtl/thr_checker.sv
// Cycle-level properties for cpu_throttle, attached through bind.
// Assumes the default encoding of thr_pkg for the fully-on state.
module thr_checker #(
    parameter int DUTY_W = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      tick,
    input logic [thr_pkg::PWR_W-1:0] pwr_state,
    input logic                      stpclk_n,
    input logic [DUTY_W-1:0]         slot_idx,
    input logic [DUTY_W-1:0]         duty_q,
    input logic                      act_q,
    input logic                      load
);
    import thr_pkg::*;

    AST_RESET_HIGH: assert property (@(posedge clk) !rst_n |=> stpclk_n); // R1

    AST_SLOT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slot_idx) |-> ($past(tick) || ($past(pwr_state) != PWR_FULL_ON))); // R2

    AST_LAST_SLOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == {DUTY_W{1'b1}}) |-> stpclk_n); // R3

    AST_LOW_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !stpclk_n |-> act_q); // R7

    AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_q) |-> $past(load)); // R8

    AST_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state != PWR_FULL_ON) |=> stpclk_n); // R9
endmodule

bind cpu_throttle thr_checker #(.DUTY_W(DUTY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pwr_state (pwr_state),
    .stpclk_n  (stpclk_n),
    .slot_idx  (slot_idx),
    .duty_q    (duty_q),
    .act_q     (act_q),
    .load      (load)
);

// File: tb/cpu_throttle_bench.sv
// Scoreboard bench: driver tasks queue the expected per-cycle output and a
// monitor pops and compares one item per cycle, 2 ns after each rising edge.
module cpu_throttle_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] pwr_state = 2'b00;
    logic [1:0] period_sel = 2'd0;
    logic       norm_en = 1'b0;
    logic [2:0] norm_duty = 3'd0;
    logic       therm_en = 1'b0;
    logic       therm_n = 1'b1;
    logic [2:0] therm_duty = 3'd0;
    logic       stpclk_n;

    int total = 0;
    int bad = 0;
    logic  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    cpu_throttle u_cpu_throttle (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_state(pwr_state),
        .period_sel(period_sel), .norm_en(norm_en), .norm_duty(norm_duty),
        .therm_en(therm_en), .therm_n(therm_n), .therm_duty(therm_duty),
        .stpclk_n(stpclk_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: stpclk_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Queue the expected output of whole periods: slot length len, duty d.
    task automatic push_periods(input int len, input int d, input int nper, input string tag);
        for (int p = 0; p < nper; p++)
            for (int k = 0; k < 8 * len; k++) begin
                exp_q.push_back((k / len) < d ? 1'b0 : 1'b1);
                tag_q.push_back(tag);
            end
    endtask

    task automatic push_const(input logic v, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Leave the fully-on state long enough for the synchronizer, then re-enter.
    task automatic enter_fon();
        @(negedge clk);
        pwr_state = 2'b01;
        repeat (4) @(negedge clk);
        pwr_state = 2'b00;
    endtask

    // Monitor: compare one queued item per cycle, away from the edges.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) check(stpclk_n, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(stpclk_n, 1'b1, "R1 during reset");
        rst_n = 1'b1;
        push_const(1'b1, 6, "R1/R7 idle after reset");
        drain();

        // R3/R4: normal mode, slot 2 ticks, duty 3
        norm_en = 1'b1; norm_duty = 3'd3; period_sel = 2'd0;
        enter_fon();
        push_periods(2, 3, 2, "R3/R4 normal duty3");
        drain();

        // R3: duty 0 never asserts
        norm_duty = 3'd0;
        enter_fon();
        push_periods(2, 0, 1, "R3 duty0");
        drain();

        // R2: longer slots, duty 5
        norm_duty = 3'd5; period_sel = 2'd2;
        enter_fon();
        push_periods(8, 5, 1, "R2 psel2 duty5");
        drain();

        // R6: both sources, thermal duty wins
        period_sel = 2'd0; norm_duty = 3'd2; therm_en = 1'b1; therm_n = 1'b0; therm_duty = 3'd6;
        enter_fon();
        push_periods(2, 6, 1, "R6 thermal priority");
        drain();

        // R5: thermal only
        norm_en = 1'b0; therm_duty = 3'd4; period_sel = 2'd1;
        enter_fon();
        push_periods(4, 4, 1, "R5 thermal only");
        drain();

        // R7: thermal pin released, nothing active
        therm_n = 1'b1;
        enter_fon();
        push_periods(2, 0, 1, "R7 no source");
        drain();

        // R8: mid-period duty and period change applies next period
        therm_en = 1'b0; norm_en = 1'b1; norm_duty = 3'd2; period_sel = 2'd0;
        enter_fon();
        push_periods(2, 2, 1, "R8 first period keeps duty2");
        push_periods(4, 6, 1, "R8 next period duty6 psel1");
        repeat (5) @(negedge clk);
        norm_duty = 3'd6; period_sel = 2'd1;
        drain();

        // R2: no ticks, slot 0 held
        norm_duty = 3'd4; period_sel = 2'd0; tick = 1'b0;
        enter_fon();
        push_const(1'b0, 20, "R2 no tick holds slot");
        drain();
        tick = 1'b1;

        // R9: leave fully-on mid-period
        norm_duty = 3'd6;
        enter_fon();
        push_const(1'b0, 4, "R9 before exit");
        drain();
        pwr_state = 2'b10;
        push_const(1'b1, 6, "R9 off deasserts");
        drain();

        // R10: re-entry restarts at slot 0
        pwr_state = 2'b00;
        push_periods(2, 6, 1, "R10 resume");
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule